// File: doc/BRIEF.md
# Line Clamp Pulse Timing Generator

This block times the DC-restore clamp of a video digitizer front end. It runs on the pixel clock and watches the horizontal sync input. On the edge where sync goes from active to inactive, it starts counting pixels. Once a programmed start offset has elapsed, it raises the clamp enable for a programmed number of pixels. In the same cycle it raises a one-cycle strobe that opens the black-level calibration window, so both functions share one starting pixel.

The start offset is assembled from two 8-bit configuration values. When the offset is set past the end of active video, the pulse lands on the front porch instead of the back porch. No other setting is needed for that. The register bus, the clamp DAC, the converter and the sync slicer sit outside this block, which receives decoded configuration values.

The line-lock PLL coast flag is sampled at the sync trailing edge. While the PLL coasts, that line's clamp is suppressed unless a policy input allows it. The clamp is forced low whenever the input is DC-coupled.

Top module: `line_clamp_gen`

## Requirements
- R1: While and after a synchronous active-low reset, `clamp_out` and `blc_strobe` are 0 until a sync trailing edge has been processed.
- R2: A trailing edge is a clock where the previous registered sample of sync was active and the current sample is inactive. `hsync_pol`=1 means sync is active high and 0 means active low. Pixel index p counts clock edges from the edge that captures the trailing edge, which is p=0.
- R3: With start offset S = {`start_hi`,`start_lo`} (high byte in bits 15:8), the clamp goes high in the cycle after edge p=S. This covers S=0 and large offsets of several hundred pixels.
- R4: The clamp stays high for exactly W cycles (p = S .. S+W-1), where W is `width`. W=0 produces no clamp pulse.
- R5: `pll_coast` is sampled at the trailing edge and held for the line. If it was 1 and `coast_clamp_en` was 0, the line has no clamp pulse. With `coast_clamp_en`=1 the pulse is produced.
- R6: While `dc_mode`=1, `clamp_out` is 0.
- R7: `blc_strobe` is high for exactly one cycle, the cycle after edge p=S, on every line. It does not depend on width, coast or coupling mode.
- R8: A new trailing edge during counting or clamping restarts the line at p=0. Any clamp in progress ends unless the new S is 0.
- R9: S, W and `coast_clamp_en` are captured only at the trailing edge. Changes in mid-line do not affect the current line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync |
| hsync_pol | input | 1 | 1: sync active high, 0: active low |
| pll_coast | input | 1 | Line-lock PLL is coasting |
| dc_mode | input | 1 | 1: DC-coupled input, clamp disabled |
| coast_clamp_en | input | 1 | 1: allow clamp while coasting |
| start_lo | input | 8 | Start offset, low byte |
| start_hi | input | 8 | Start offset, high byte |
| width | input | 8 | Clamp width in pixels |
| clamp_out | output | 1 | Clamp enable |
| blc_strobe | output | 1 | Black-level window start strobe |

## Verification
The bench targets the offsets 0 and 1, where an off-by-one counter starts the clamp one pixel late or misses it. It also uses a width of zero, which a careless decrement would turn into a 256-pixel pulse. A 300-pixel offset checks that the high byte is used; a design that dropped it would clamp inside the back porch. Further cases are a short line whose next edge lands in the middle of a clamp, a coast flag that drops in mid-line, and register writes in mid-line. A design that did not latch these values at the edge would cut, stretch or re-enable the pulse on the current line.

// File: rtl/lcg_pkg.sv
// Shared types for the line clamp generator.
package lcg_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_ON   = 2'd2
    } lcg_phase_e;
endpackage

// File: rtl/lcg_edge.sv
// Sync trailing-edge detector.
// Normalises sync to active-high with the polarity input. Flags the clock
// where a registered active sample is followed by an inactive one.
// Assumes sync is already synchronous to the pixel clock.
module lcg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_in,
    input  logic hsync_pol,
    output logic trail
);
    logic act;
    logic act_q;

    // normalise polarity
    assign act   = hsync_pol ? hsync_in : ~hsync_in;
    assign trail = act_q & ~act;

    // remember last normalised sample
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act;
    end

    // R2
    trail_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trail |=> !trail);
endmodule

// File: rtl/lcg_seq.sv
// Per-line pixel sequencer.
// On a trailing edge it captures the start offset, width and coast
// permission. It waits the start offset, strobes once, then holds the
// clamp for the width. A new trailing edge always restarts the line.
module lcg_seq import lcg_pkg::*; #(
    parameter int OFS_W = 16,
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trail,
    input  logic [OFS_W-1:0] start_ofs,
    input  logic [WID_W-1:0] width,
    input  logic             coast,
    input  logic             coast_ok,
    output logic             clamp_q,
    output logic             strobe
);
    localparam int CNT_W = (OFS_W > WID_W) ? OFS_W : WID_W;

    lcg_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    logic [WID_W-1:0] wid_r;
    logic             ok_r;
    logic             ok_now;

    // permission for a line starting this cycle
    assign ok_now = ~coast | coast_ok;

    // line sequencing: restart, wait, strobe, clamp
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            wid_r   <= '0;
            ok_r    <= 1'b0;
            clamp_q <= 1'b0;
            strobe  <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (trail) begin
                wid_r <= width;
                ok_r  <= ok_now;
                if (start_ofs == '0) begin
                    strobe <= 1'b1;
                    if (width != '0 && ok_now) begin
                        phase   <= PH_ON;
                        clamp_q <= 1'b1;
                        cnt     <= CNT_W'(width) - 1'b1;
                    end else begin
                        phase   <= PH_IDLE;
                        clamp_q <= 1'b0;
                    end
                end else begin
                    phase   <= PH_WAIT;
                    clamp_q <= 1'b0;
                    cnt     <= CNT_W'(start_ofs) - 1'b1;
                end
            end else begin
                case (phase)
                    PH_WAIT: begin
                        if (cnt == '0) begin
                            strobe <= 1'b1;
                            if (wid_r != '0 && ok_r) begin
                                phase   <= PH_ON;
                                clamp_q <= 1'b1;
                                cnt     <= CNT_W'(wid_r) - 1'b1;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    PH_ON: begin
                        if (cnt == '0) begin
                            phase   <= PH_IDLE;
                            clamp_q <= 1'b0;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // R7
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !trail) |=> !strobe);

    // R3
    clamp_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_q) |-> strobe);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!clamp_q && !strobe));
endmodule

// File: rtl/line_clamp_gen.sv
// Line clamp pulse timing generator, top level.
// Joins the offset bytes, detects the sync trailing edge, sequences the
// clamp and strobe, and masks the clamp in DC-coupled mode.
// Assumes all inputs are synchronous to the pixel clock.
module line_clamp_gen #(
    parameter int BYTE_W = 8,
    parameter int WID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_in,
    input  logic              hsync_pol,
    input  logic              pll_coast,
    input  logic              dc_mode,
    input  logic              coast_clamp_en,
    input  logic [BYTE_W-1:0] start_lo,
    input  logic [BYTE_W-1:0] start_hi,
    input  logic [WID_W-1:0]  width,
    output logic              clamp_out,
    output logic              blc_strobe
);
    localparam int OFS_W = 2 * BYTE_W;

    logic             trail;
    logic             clamp_q;
    logic [OFS_W-1:0] start_ofs;

    assign start_ofs = {start_hi, start_lo};

    lcg_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync_in  (hsync_in),
        .hsync_pol (hsync_pol),
        .trail     (trail)
    );

    lcg_seq #(.OFS_W(OFS_W), .WID_W(WID_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trail     (trail),
        .start_ofs (start_ofs),
        .width     (width),
        .coast     (pll_coast),
        .coast_ok  (coast_clamp_en),
        .clamp_q   (clamp_q),
        .strobe    (blc_strobe)
    );

    // DC coupling masks the clamp
    assign clamp_out = clamp_q & ~dc_mode;

    // R8
    restart_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trail |=> (!clamp_out || $past(start_ofs == '0)));
endmodule

// File: tb/line_clamp_gen_tb.sv
module line_clamp_gen_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync_in = 1'b0, hsync_pol = 1'b1, pll_coast = 1'b0;
    logic dc_mode = 1'b0, coast_clamp_en = 1'b0;
    logic [7:0] start_lo = 8'd5, start_hi = 8'd0, width = 8'd4;
    logic clamp_out, blc_strobe;

    int checks = 0;
    int errors = 0;
    string req_tag = "R1";
    bit done = 1'b0;

    always #5 clk = ~clk;

    line_clamp_gen u_dut (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .hsync_pol(hsync_pol),
        .pll_coast(pll_coast), .dc_mode(dc_mode), .coast_clamp_en(coast_clamp_en),
        .start_lo(start_lo), .start_hi(start_hi), .width(width),
        .clamp_out(clamp_out), .blc_strobe(blc_strobe)
    );

    // behavioural reference: pixel index since last trailing edge
    int  m_p = -1;
    int  m_s = 0;
    int  m_w = 0;
    bit  m_ok = 1'b0;
    bit  m_prev = 1'b0;
    bit  exp_clamp_raw = 1'b0;
    bit  exp_strobe = 1'b0;

    always @(posedge clk) begin
        bit act;
        act = hsync_pol ? hsync_in : !hsync_in;
        if (!rst_n) begin
            m_p = -1;
            m_prev = 1'b0;
        end else begin
            if (m_prev && !act) begin
                m_p  = 0;
                m_s  = {start_hi, start_lo};
                m_w  = width;
                m_ok = !pll_coast || coast_clamp_en;
            end else if (m_p >= 0 && m_p < 100000) begin
                m_p = m_p + 1;
            end
            m_prev = act;
        end
        exp_strobe    = (m_p >= 0) && (m_p == m_s);
        exp_clamp_raw = (m_p >= 0) && m_ok && (m_p >= m_s) && (m_p < m_s + m_w);
    end

    // compare on every clock, mid-cycle
    always @(negedge clk) begin
        bit ec;
        if (!done) begin
            ec = exp_clamp_raw && !dc_mode;
            checks++;
            if (clamp_out !== ec) begin
                errors++;
                $display("FAIL %s clamp_out actual=%0b expected=%0b t=%0t", req_tag, clamp_out, ec, $time);
            end
            checks++;
            if (blc_strobe !== exp_strobe) begin
                errors++;
                $display("FAIL %s blc_strobe actual=%0b expected=%0b t=%0t", req_tag, blc_strobe, exp_strobe, $time);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // one line: sync active for act_len, inactive for idle_len
    task automatic line(input int act_len, input int idle_len);
        hsync_in = hsync_pol;
        tick(act_len);
        hsync_in = !hsync_pol;
        tick(idle_len);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, sync held active through reset
        req_tag = "R1";
        hsync_in = 1'b1;
        tick(4);
        rst_n = 1'b1;
        tick(3);
        hsync_in = 1'b0;
        tick(1);
        hsync_in = 1'b0;

        // R2 R3 R4: active-high sync, S=5 W=4
        req_tag = "R3";
        start_lo = 8'd5; width = 8'd4;
        line(3, 20); line(3, 20);
        // R2: active-low sync
        req_tag = "R2";
        hsync_pol = 1'b0; hsync_in = 1'b1; tick(3);
        line(4, 25); line(4, 25);
        hsync_pol = 1'b1; hsync_in = 1'b0; tick(3);
        // R3: offsets 0 and 1
        req_tag = "R3";
        start_lo = 8'd0; width = 8'd3; line(2, 12);
        start_lo = 8'd1; line(2, 12);
        // R4: width 0 and width 1
        req_tag = "R4";
        start_lo = 8'd2; width = 8'd0; line(2, 12);
        width = 8'd1; line(2, 12);
        // R5: coasting, suppress then allow
        req_tag = "R5";
        width = 8'd4; pll_coast = 1'b1; coast_clamp_en = 1'b0; line(2, 15);
        coast_clamp_en = 1'b1; line(2, 15);
        coast_clamp_en = 1'b0;
        // R5: coast drops in mid-line, line stays suppressed
        hsync_in = 1'b1; tick(2); hsync_in = 1'b0; tick(1);
        pll_coast = 1'b0; tick(14);
        // R6 R7: DC mode keeps clamp low, strobe still present
        req_tag = "R6";
        dc_mode = 1'b1; line(2, 15);
        req_tag = "R7";
        width = 8'd0; line(2, 15);
        dc_mode = 1'b0; width = 8'd4;
        // R3: front-porch offset 0x012C = 300 uses high byte
        req_tag = "R3";
        start_hi = 8'h01; start_lo = 8'h2C; width = 8'd6; line(3, 320);
        start_hi = 8'h00;
        // R8: next edge arrives during the clamp
        req_tag = "R8";
        start_lo = 8'd3; width = 8'd10; line(2, 6); line(2, 20);
        // R8: restart during wait, new S=0 while clamping
        line(2, 2); start_lo = 8'd0; line(2, 3); line(2, 15);
        // R9: mid-line writes ignored until next edge
        req_tag = "R9";
        start_lo = 8'd4; width = 8'd3;
        hsync_in = 1'b1; tick(2); hsync_in = 1'b0; tick(2);
        start_lo = 8'd1; width = 8'd9; coast_clamp_en = 1'b1; pll_coast = 1'b1;
        tick(15);
        pll_coast = 1'b0; coast_clamp_en = 1'b0;
        line(2, 15);
        tick(5);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule